// File: doc/BRIEF.md
# Configuration Access Bridge

This block sits between a CPU-side memory bus and a configuration request port. It offers two windows of 4 KB each. The pointer window holds one 32-bit configuration pointer, and a write anywhere in that window loads it. The data window turns every access into exactly one configuration request. The outgoing address is built from the stored pointer and the low three bits of the data-window offset.

The pointer can take one of three layouts. The layout is chosen by pointer bit 31 and bit 0:

- **Raw:** bit 31 set. The pointer passes through as the address.
- **Flat:** bit 31 clear, bit 0 set. The pointer supplies the upper bits and the window offset supplies the low three bits.
- **Slot-select:** bits 31 and 0 both clear. Bits [31:11] are a one-hot-style slot mask. The position of its lowest set bit becomes the binary device number of a standard configuration address. If no bit in the mask is set, the access completes at once with a flag and no request is issued.

Data is byte-reversed within the access length in both directions. This converts between the CPU's byte order and the configuration bus's byte order.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the pointer reads as zero, and both `cpu_ack` and `cfg_valid` are low.
- R2: A pointer-window write (`cpu_addr[12]`=0) stores all 32 bits of `cpu_wdata` at any offset. A pointer-window read returns the stored pointer unchanged. Neither kind of access raises `cfg_valid`.
- R3: Raw layout (pointer bit 31 = 1): `cfg_addr` = pointer OR data-window offset bits [1:0].
- R4: Flat layout (bit 31 = 0, bit 0 = 1): `cfg_addr` = {pointer[31:3], offset[2:0]}.
- R5: Slot-select layout (bits 31 and 0 both 0):
  - `cfg_addr[15:11]` is the index of the lowest set bit of pointer[31:11], where pointer bit 11 is index 0.
  - `cfg_addr[10:3]` = pointer[10:3] (function number and register offset).
  - `cfg_addr[2:0]` = offset[2:0].
  - `cfg_addr[31:16]` = 0.
- R6: In the slot-select layout with pointer[31:11] all zero, no request is issued. The access acknowledges with `cpu_nodev`=1 and `cpu_rdata`=32'hFFFFFFFF, and a write is dropped.
- R7: `cpu_size` codes the access length: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Write data is byte-reversed within that length and placed in the low bytes of `cfg_wdata`, with the upper bytes zero.
- R8: Read data from `cfg_rdata` is byte-reversed within the access length in the same way, and returned on `cpu_rdata` with the upper bytes zero.
- R9: The request is held with stable fields while `cfg_valid` is high and `cfg_ready` is low. `cpu_ack` rises only after the handshake and lasts one cycle.
- R10: `cpu_addr[12]` selects the window (1 = data window). Offset bits [11:3] have no effect on either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 13 | Bit 12 selects the window; bits [11:0] are the window offset |
| cpu_size | input | 2 | Access length code |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ack | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| cpu_nodev | output | 1 | Empty slot mask flag, valid with `cpu_ack` |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration request accepted |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_size | output | 2 | Access length code, forwarded |
| cfg_wdata | output | 32 | Byte-reversed write data |
| cfg_rdata | input | 32 | Target read data, valid with `cfg_ready` |

## Verification
The bench covers each pointer layout with several patterns:
- A slot mask with one bit or many bits set. If the find-first-set encoder picked the highest bit, or used the wrong base, the device field would be wrong.
- A pointer with both bit 31 and bit 0 set. A layout decoder with the wrong priority would clear the low bits.
- Every access length. A swap that ignored the length would leak upper bytes or misplace the low ones.

It also checks these corner cases:
- An empty slot mask must produce no request and must return all ones. A design that issued the request anyway, or forwarded the write, would show up in the target's capture count.
- Stalls on `cfg_ready`, where an early or doubled acknowledge would be seen.
- Offsets in the upper part of a window, where mistakes in the offset decode would surface.

// File: rtl/cab_pkg.sv
package cab_pkg;

  localparam int CAB_DW = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } cab_state_e;

  typedef enum logic [1:0] {
    FMT_RAW  = 2'd0,
    FMT_FLAT = 2'd1,
    FMT_SLOT = 2'd2
  } cab_fmt_e;

  // Byte reversal within the access length; result sits in the low bytes.
  function automatic logic [CAB_DW-1:0] cab_swap(input logic [CAB_DW-1:0] d,
                                                 input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  // Layout decode: bit 31 has priority over bit 0.
  function automatic cab_fmt_e cab_layout(input logic [CAB_DW-1:0] p);
    if (p[CAB_DW-1])  return FMT_RAW;
    else if (p[0])    return FMT_FLAT;
    else              return FMT_SLOT;
  endfunction

endpackage

// File: rtl/cab_ptr_reg.sv
module cab_ptr_reg #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_data,
  output logic [PTR_W-1:0] ptr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= wr_data;
  end

endmodule

// File: rtl/cab_addr_xlate.sv
module cab_addr_xlate
  import cab_pkg::*;
#(
  parameter int PTR_W   = 32,
  parameter int SEL_LSB = 11
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [2:0]       win_lo,
  output logic [PTR_W-1:0] xl_addr,
  output logic             xl_nodev,
  output cab_fmt_e         xl_fmt
);

  localparam int SEL_N = PTR_W - SEL_LSB;
  localparam int IDX_W = $clog2(SEL_N);

  logic [SEL_N-1:0] sel;
  logic [SEL_N-1:0] first;
  logic [SEL_N:0]   seen;
  logic [IDX_W-1:0] idx;

  assign sel     = ptr[PTR_W-1:SEL_LSB];
  assign seen[0] = 1'b0;

  // Lowest-set-bit isolation chain.
  generate
    for (genvar i = 0; i < SEL_N; i++) begin : g_ffs
      assign first[i]    = sel[i] & ~seen[i];
      assign seen[i + 1] = seen[i] | sel[i];
    end
  endgenerate

  // One-hot to binary.
  always_comb begin
    idx = '0;
    for (int i = 0; i < SEL_N; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

  assign xl_fmt = cab_layout(ptr);

  always_comb begin
    xl_addr = '0;
    case (xl_fmt)
      FMT_RAW:  xl_addr = ptr | {{(PTR_W-2){1'b0}}, win_lo[1:0]};
      FMT_FLAT: xl_addr = {ptr[PTR_W-1:3], win_lo};
      default: begin
        xl_addr[SEL_LSB+IDX_W-1:SEL_LSB] = idx;
        xl_addr[SEL_LSB-1:3]             = ptr[SEL_LSB-1:3];
        xl_addr[2:0]                     = win_lo;
      end
    endcase
  end

  assign xl_nodev = (xl_fmt == FMT_SLOT) && !seen[SEL_N];

endmodule

// File: rtl/cab_ctrl.sv
module cab_ctrl
  import cab_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          data_win,
  input  logic [1:0]    cpu_size,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] ptr_q,
  input  logic [DW-1:0] xl_addr,
  input  logic          xl_nodev,
  output logic          ptr_wr_en,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_nodev,
  output logic          cfg_valid,
  input  logic          cfg_ready,
  output logic          cfg_we,
  output logic [DW-1:0] cfg_addr,
  output logic [1:0]    cfg_size,
  output logic [DW-1:0] cfg_wdata,
  input  logic [DW-1:0] cfg_rdata,
  output cab_state_e    state_q
);

  cab_state_e    state_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          nodev_q, nodev_d;
  logic          rq_load;

  always_comb begin
    state_d   = state_q;
    rd_d      = rd_q;
    nodev_d   = nodev_q;
    ptr_wr_en = 1'b0;
    rq_load   = 1'b0;
    case (state_q)
      ST_IDLE: if (cpu_req) begin
        nodev_d = 1'b0;
        if (!data_win) begin
          ptr_wr_en = cpu_we;
          rd_d      = cpu_we ? '0 : ptr_q;
          state_d   = ST_RESP;
        end else if (xl_nodev) begin
          nodev_d = 1'b1;
          rd_d    = '1;
          state_d = ST_RESP;
        end else begin
          rq_load = 1'b1;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: if (cfg_ready) begin
        rd_d    = cfg_we ? '0 : cab_swap(cfg_rdata, cfg_size);
        state_d = ST_RESP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_q      <= '0;
      nodev_q   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_size  <= '0;
      cfg_wdata <= '0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      nodev_q <= nodev_d;
      if (rq_load) begin
        cfg_we    <= cpu_we;
        cfg_addr  <= xl_addr;
        cfg_size  <= cpu_size;
        cfg_wdata <= cpu_we ? cab_swap(cpu_wdata, cpu_size) : '0;
      end
    end
  end

  assign cfg_valid = (state_q == ST_ISSUE);
  assign cpu_ack   = (state_q == ST_RESP);
  assign cpu_rdata = rd_q;
  assign cpu_nodev = nodev_q;

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cab_pkg::*;
#(
  parameter int WIN_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [WIN_AW:0]   cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic [CAB_DW-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [CAB_DW-1:0] cpu_rdata,
  output logic              cpu_nodev,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic              cfg_we,
  output logic [CAB_DW-1:0] cfg_addr,
  output logic [1:0]        cfg_size,
  output logic [CAB_DW-1:0] cfg_wdata,
  input  logic [CAB_DW-1:0] cfg_rdata
);

  logic              data_win;
  logic              ptr_wr_en;
  logic [CAB_DW-1:0] ptr_q;
  logic [CAB_DW-1:0] xl_addr;
  logic              xl_nodev;
  cab_fmt_e          xl_fmt;
  cab_state_e        state_q;
  // Named events for the checker.
  logic              state_idle;
  logic              data_start;
  logic              unused_offset_bits;

  assign data_win           = cpu_addr[WIN_AW];
  assign state_idle         = (state_q == ST_IDLE);
  assign data_start         = state_idle && cpu_req && data_win;
  assign unused_offset_bits = ^{cpu_addr[WIN_AW-1:3], xl_fmt};

  cab_ptr_reg #(.PTR_W(CAB_DW)) i_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ptr_wr_en),
    .wr_data (cpu_wdata),
    .ptr_q   (ptr_q)
  );

  cab_addr_xlate #(.PTR_W(CAB_DW), .SEL_LSB(11)) i_xlate (
    .ptr      (ptr_q),
    .win_lo   (cpu_addr[2:0]),
    .xl_addr  (xl_addr),
    .xl_nodev (xl_nodev),
    .xl_fmt   (xl_fmt)
  );

  cab_ctrl #(.DW(CAB_DW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .data_win  (data_win),
    .cpu_size  (cpu_size),
    .cpu_wdata (cpu_wdata),
    .ptr_q     (ptr_q),
    .xl_addr   (xl_addr),
    .xl_nodev  (xl_nodev),
    .ptr_wr_en (ptr_wr_en),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata),
    .cpu_nodev (cpu_nodev),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_size  (cfg_size),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .state_q   (state_q)
  );

endmodule

// File: rtl/cab_checker.sv
module cab_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ack,
  input logic        cpu_nodev,
  input logic [31:0] cpu_rdata,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        cfg_we,
  input logic [31:0] cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] ptr_q,
  input logic        xl_nodev,
  input logic        data_start
);

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr)
                                && $stable(cfg_wdata) && $stable(cfg_we));

  assert_nodev_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_start && xl_nodev |=> !cfg_valid && cpu_ack && cpu_nodev);

  assert_nodev_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && cpu_nodev |-> cpu_rdata == 32'hFFFF_FFFF);

  assert_raw_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && ptr_q[31] |-> cfg_addr[31:2] == ptr_q[31:2]);

  assert_flat_layout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !ptr_q[31] && ptr_q[0] |-> cfg_addr[31:3] == ptr_q[31:3]);

  assert_slot_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !ptr_q[31] && !ptr_q[0]
      |-> cfg_addr[31:16] == 16'h0 && cfg_addr[10:3] == ptr_q[10:3]);

endmodule

bind cfg_access_bridge cab_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_ack    (cpu_ack),
  .cpu_nodev  (cpu_nodev),
  .cpu_rdata  (cpu_rdata),
  .cfg_valid  (cfg_valid),
  .cfg_ready  (cfg_ready),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .ptr_q      (ptr_q),
  .xl_nodev   (xl_nodev),
  .data_start (data_start)
);

// File: tb/test_cfg_access_bridge.sv
module test_cfg_access_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ack, cpu_nodev, cfg_valid, cfg_we;
  logic [31:0] cpu_rdata, cfg_addr, cfg_wdata;
  logic [1:0]  cfg_size;
  logic        cfg_ready = 1'b0;
  logic [31:0] cfg_rdata = '0;

  always #2.5 clk = ~clk;

  cfg_access_bridge i_cfg_access_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_nodev(cpu_nodev),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int checks = 0, fails = 0;
  int stall = 0, cap_count = 0;
  logic [31:0] resp_data = '0, cap_addr = '0, cap_wdata = '0;
  logic        cap_we = 1'b0;

  typedef struct packed {
    logic [31:0] ptr;
    logic [2:0]  off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] tr;
    logic [31:0] ea;
    logic [31:0] ew;
    logic [31:0] er;
    logic        nd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_1234, 3'd3, 2'd2, 32'h1122_3344, 32'hA1B2_C3D4, 32'h8000_1237, 32'h4433_2211, 32'hD4C3_B2A1, 1'b0, 4'd3},
    '{32'h0012_3451, 3'd6, 2'd1, 32'h0000_BEEF, 32'h5555_1234, 32'h0012_3456, 32'h0000_EFBE, 32'h0000_3412, 1'b0, 4'd4},
    '{32'h0000_0800, 3'd0, 2'd0, 32'hFFFF_FF5A, 32'hCCCC_CC77, 32'h0000_0000, 32'h0000_005A, 32'h0000_0077, 1'b0, 4'd5},
    '{32'h0000_25A8, 3'd5, 2'd2, 32'hDEAD_BEEF, 32'h0102_0304, 32'h0000_15AD, 32'hEFBE_ADDE, 32'h0403_0201, 1'b0, 4'd5},
    '{32'h4000_0304, 3'd7, 2'd1, 32'h0000_1234, 32'h0000_ABCD, 32'h0000_9B07, 32'h0000_3412, 32'h0000_CDAB, 1'b0, 4'd5},
    '{32'h0F00_C000, 3'd2, 2'd2, 32'h0A0B_0C0D, 32'h1020_3040, 32'h0000_1802, 32'h0D0C_0B0A, 32'h4030_2010, 1'b0, 4'd5},
    '{32'h0000_07F8, 3'd1, 2'd2, 32'h1234_5678, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'd6},
    '{32'h8000_0001, 3'd6, 2'd3, 32'h0123_4567, 32'h89AB_CDEF, 32'h8000_0003, 32'h6745_2301, 32'hEFCD_AB89, 1'b0, 4'd3}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Target model on the request port.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cfg_ready) begin
        cfg_ready = 1'b0;
        cnt = 0;
      end else if (cfg_valid) begin
        if (cnt >= stall) begin
          cfg_ready = 1'b1;
          cfg_rdata = resp_data;
          cap_addr  = cfg_addr;
          cap_wdata = cfg_wdata;
          cap_we    = cfg_we;
          cap_count++;
        end else cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    summary();
  end

  task automatic access(input bit dwin, input logic [11:0] off, input bit we,
                        input logic [1:0] sz, input logic [31:0] wd,
                        output logic [31:0] rd, output logic nd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = {dwin, off};
    cpu_size = sz; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(posedge clk);
      #1;
      cyc++;
    end while (!cpu_ack && cyc < 1000);
    rd = cpu_rdata;
    nd = cpu_nodev;
    cpu_req = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    logic nd;
    int cyc, base;

    repeat (3) @(posedge clk);
    #1;
    check(!cpu_ack && !cfg_valid, "R1 outputs idle in reset",
          {30'h0, cpu_ack, cfg_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    access(1'b0, 12'h000, 1'b0, 2'd2, 32'h0, rd, nd, cyc);
    check(rd == 32'h0, "R1 pointer zero after reset", rd, 32'h0);

    // R2/R10: pointer window write at a high offset, read back elsewhere.
    base = cap_count;
    access(1'b0, 12'hABC, 1'b1, 2'd0, 32'hCAFE_F00D, rd, nd, cyc);
    access(1'b0, 12'hFF8, 1'b0, 2'd0, 32'h0, rd, nd, cyc);
    check(rd == 32'hCAFE_F00D, "R2 R10 pointer read back", rd, 32'hCAFE_F00D);
    check(cap_count == base, "R2 no request from pointer window", cap_count, base);

    // Vector walk: program pointer, data write, data read.
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d R7 R8 R10 vec%0d", VECS[v].req, v);
      access(1'b0, 12'h004, 1'b1, 2'd2, VECS[v].ptr, rd, nd, cyc);
      base = cap_count;
      access(1'b1, {9'h1F5, VECS[v].off}, 1'b1, VECS[v].sz, VECS[v].wd, rd, nd, cyc);
      if (VECS[v].nd) begin
        check(cap_count == base && nd, {tag, " write dropped"}, cap_count, base);
      end else begin
        check(cap_count == base + 1 && cap_we && cap_addr == VECS[v].ea,
              {tag, " write addr"}, cap_addr, VECS[v].ea);
        check(cap_wdata == VECS[v].ew, {tag, " write data"}, cap_wdata, VECS[v].ew);
      end
      resp_data = VECS[v].tr;
      base = cap_count;
      access(1'b1, {9'h0A3, VECS[v].off}, 1'b0, VECS[v].sz, 32'h0, rd, nd, cyc);
      check(rd == VECS[v].er && nd == VECS[v].nd, {tag, " read data"}, rd, VECS[v].er);
      if (!VECS[v].nd)
        check(cap_count == base + 1 && !cap_we && cap_addr == VECS[v].ea,
              {tag, " read addr"}, cap_addr, VECS[v].ea);
      else
        check(cap_count == base, {tag, " no read request"}, cap_count, base);
    end

    // R9: stalled target; acknowledge only after handshake, one cycle long.
    stall = 4;
    access(1'b0, 12'h0, 1'b1, 2'd2, 32'h0000_1000, rd, nd, cyc);
    resp_data = 32'h1122_3344;
    base = cap_count;
    access(1'b1, 12'h002, 1'b0, 2'd2, 32'h0, rd, nd, cyc);
    check(cap_count == base + 1 && cyc >= 6, "R9 ack waits for handshake", cyc, 6);
    check(rd == 32'h4433_2211 && cap_addr == 32'h0000_0802, "R5 R9 stalled read",
          rd, 32'h4433_2211);
    @(posedge clk);
    #1;
    check(!cpu_ack, "R9 ack one cycle", {31'h0, cpu_ack}, 32'h0);
    stall = 0;

    // R1: reset clears the pointer.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 12'h0, 1'b0, 2'd2, 32'h0, rd, nd, cyc);
    check(rd == 32'h0, "R1 pointer cleared by reset", rd, 32'h0);

    summary();
  end

endmodule